// File: doc/BRIEF.md
# Fallback Image Selection Controller

This block chooses which configuration page a device loads next, after power-up and after every later reconfiguration trigger. It holds a 21-bit control word and a 5-bit cause register. The control word names the page to load, says whether that page is an application image or the factory image, and carries watchdog settings for the next image. The cause register records which event started the most recent reconfiguration.

From the control word the block drives a 3-bit page select and a 24-bit serial-flash start address. The five trigger inputs are external reset, external status error, CRC error, core reconfiguration request and watchdog timeout. A staged update word is an input; it becomes the control word only when the core requests a reconfiguration in remote mode. In local mode the control word cannot be written. Each decision sends a one-cycle `load_start` pulse, and the block then holds its outputs until the loader answers with `load_done`.

All pins are plain control and status levels or pulses. There is no streaming data path, so no valid/ready handshake and no back-pressure. The mode input selects remote update (1) or local update (0). Reset is synchronous and active low, and the mode level seen during reset sets the power-up control word.

Top module: `imgsel_ctrl`

## Requirements
- R1: While reset is held, the cause register is 0. The control word is 0 in remote mode and 21'h000003 in local mode (application flag set, page 1). The first cycle after the first clock edge with reset released carries a `load_start` pulse.
- R2: The control word layout is: bit 0 application flag, bits 3:1 page[2:0], bits 7:4 page[6:3], bit 8 watchdog enable, bits 20:9 watchdog limit. `page_sel` equals page[2:0], and `flash_start_addr` equals {1'b0, page[6:0], 16'h0000}.
- R3: In remote mode, a reconfiguration won by external reset, status error, CRC error or watchdog timeout clears the whole control word.
- R4: In remote mode, a reconfiguration won by a core request copies `upd_word` into the control word unchanged.
- R5: In local mode, a reconfiguration won by external reset or core request sets the control word to 21'h000003, whatever `upd_word` holds.
- R6: In local mode, a reconfiguration won by status error, CRC error or watchdog timeout clears the whole control word.
- R7: Each accepted reconfiguration writes the cause register one-hot with the winning cause: bit 0 CRC error, bit 1 status error, bit 2 core request, bit 3 external reset, bit 4 watchdog timeout.
- R8: When several triggers arrive in the same cycle, the winner is chosen in this order: external reset, then status error, then CRC error, then watchdog timeout, then core request.
- R9: `load_start` is high for exactly one cycle, in the cycle after the control word changes. `loading` is high from that pulse until the cycle after `load_done` is sampled while waiting.
- R10: Triggers that arrive while `loading` is high are ignored. The control word and the cause register do not change.
- R11: `wdog_limit` always shows control bits 20:9. `wdog_en` shows control bit 8 in remote mode and is 0 in local mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| remote_mode | input | 1 | 1 selects remote update, 0 selects local update |
| trig_ext_rst | input | 1 | External reset trigger |
| trig_stat_err | input | 1 | External status error trigger |
| trig_crc_err | input | 1 | CRC error trigger |
| trig_core_req | input | 1 | Core reconfiguration request |
| trig_wdog_to | input | 1 | Watchdog timeout trigger |
| upd_word | input | 21 | Staged update control word |
| load_done | input | 1 | Loader finished the current image |
| ctrl_word | output | 21 | Current control word |
| status_cause | output | 5 | Cause of the last reconfiguration |
| page_sel | output | 3 | Low page bits for the external page lookup |
| flash_start_addr | output | 24 | Serial-flash start address of the selected page |
| wdog_en | output | 1 | Watchdog enable for the loaded image |
| wdog_limit | output | 12 | Watchdog timeout value |
| load_start | output | 1 | One-cycle start pulse for the loader |
| loading | output | 1 | A load is in progress and triggers are ignored |

## Verification
Each trigger is fired alone in both modes. This separates the one path that copies the staged word (a core request in remote mode) from the fixed page-1 answer in local mode and from the clearing paths. The staged word carries distinct values in every field, including a page with both high and low bits set, so any misplaced field shows up in `page_sel`, the start address or the watchdog outputs. Simultaneous trigger groups remove the current winner one step at a time, which pins down the full priority chain. Triggers sent during a load, and a mode flip with watchdog enable set in the control word, show that the busy window and the local-mode watchdog gating hold.

// File: rtl/imgsel_pkg.sv
package imgsel_pkg;
  localparam int CTRL_W     = 21;
  localparam int CAUSE_W    = 5;
  localparam int PAGE_W     = 7;
  localparam int PIN_W      = 3;
  localparam int WDT_W      = 12;
  localparam int ADDR_W     = 24;
  localparam int ADDR_SHIFT = 16;

  localparam int APP_POS     = 0;
  localparam int PAGE_LO_POS = 1;
  localparam int PAGE_HI_POS = PAGE_LO_POS + PIN_W;
  localparam int PAGE_HI_W   = PAGE_W - PIN_W;
  localparam int WDEN_POS    = PAGE_LO_POS + PAGE_W;
  localparam int WDT_POS     = WDEN_POS + 1;
  localparam int ADDR_PAD_W  = ADDR_W - PAGE_W - ADDR_SHIFT;

  localparam int C_CRC  = 0;
  localparam int C_STAT = 1;
  localparam int C_CORE = 2;
  localparam int C_XRST = 3;
  localparam int C_WDOG = 4;

  localparam int PRIO [CAUSE_W] = '{C_XRST, C_STAT, C_CRC, C_WDOG, C_CORE};

  typedef logic [CTRL_W-1:0]  ctrl_word_t;
  typedef logic [CAUSE_W-1:0] cause_vec_t;

  typedef enum logic [1:0] {ST_BOOT, ST_KICK, ST_WAIT, ST_RUN} seq_state_t;

  function automatic ctrl_word_t local_app_word();
    ctrl_word_t w;
    w = '0;
    w[APP_POS] = 1'b1;
    w[PAGE_LO_POS] = 1'b1;
    return w;
  endfunction
endpackage

// File: rtl/imgsel_arb.sv
module imgsel_arb
  import imgsel_pkg::*;
(
  input  cause_vec_t req,
  output cause_vec_t grant,
  output logic       any_req
);
  always_comb begin
    logic found;
    grant = '0;
    found = 1'b0;
    for (int i = 0; i < CAUSE_W; i++) begin
      if (!found && req[PRIO[i]]) begin
        grant[PRIO[i]] = 1'b1;
        found = 1'b1;
      end
    end
    any_req = |req;
  end
endmodule

// File: rtl/imgsel_next.sv
module imgsel_next
  import imgsel_pkg::*;
(
  input  logic       remote_mode,
  input  cause_vec_t grant,
  input  ctrl_word_t upd_word,
  output ctrl_word_t next_word
);
  always_comb begin
    next_word = '0;
    if (remote_mode) begin
      if (grant[C_CORE]) next_word = upd_word;
    end else if (grant[C_XRST] || grant[C_CORE]) begin
      next_word = local_app_word();
    end
  end
endmodule

// File: rtl/imgsel_seq.sv
module imgsel_seq
  import imgsel_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic any_req,
  input  logic load_done,
  output logic load_start,
  output logic loading,
  output logic accept
);
  seq_state_t st;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_BOOT;
    end else begin
      unique case (st)
        ST_BOOT: st <= ST_KICK;
        ST_KICK: st <= ST_WAIT;
        ST_WAIT: if (load_done) st <= ST_RUN;
        ST_RUN:  if (any_req) st <= ST_KICK;
        default: st <= ST_BOOT;
      endcase
    end
  end

  assign load_start = (st == ST_KICK);
  assign loading    = (st != ST_RUN);
  assign accept     = (st == ST_RUN) && any_req;

  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    load_start |=> !load_start); // R9
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    load_start |=> loading); // R9
endmodule

// File: rtl/imgsel_ctrl.sv
module imgsel_ctrl
  import imgsel_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              remote_mode,
  input  logic              trig_ext_rst,
  input  logic              trig_stat_err,
  input  logic              trig_crc_err,
  input  logic              trig_core_req,
  input  logic              trig_wdog_to,
  input  logic [CTRL_W-1:0] upd_word,
  input  logic              load_done,
  output logic [CTRL_W-1:0] ctrl_word,
  output logic [CAUSE_W-1:0] status_cause,
  output logic [PIN_W-1:0]  page_sel,
  output logic [ADDR_W-1:0] flash_start_addr,
  output logic              wdog_en,
  output logic [WDT_W-1:0]  wdog_limit,
  output logic              load_start,
  output logic              loading
);
  cause_vec_t req, grant;
  logic       any_req, accept;
  ctrl_word_t next_word, ctrl_q;
  cause_vec_t status_q;
  logic [PAGE_W-1:0] page_full;

  always_comb begin
    req = '0;
    req[C_CRC]  = trig_crc_err;
    req[C_STAT] = trig_stat_err;
    req[C_CORE] = trig_core_req;
    req[C_XRST] = trig_ext_rst;
    req[C_WDOG] = trig_wdog_to;
  end

  imgsel_arb u_arb (
    .req     (req),
    .grant   (grant),
    .any_req (any_req)
  );

  imgsel_next u_next (
    .remote_mode (remote_mode),
    .grant       (grant),
    .upd_word    (upd_word),
    .next_word   (next_word)
  );

  imgsel_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .any_req    (any_req),
    .load_done  (load_done),
    .load_start (load_start),
    .loading    (loading),
    .accept     (accept)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q   <= remote_mode ? '0 : local_app_word();
      status_q <= '0;
    end else if (accept) begin
      ctrl_q   <= next_word;
      status_q <= grant;
    end
  end

  assign page_full        = {ctrl_q[PAGE_HI_POS +: PAGE_HI_W], ctrl_q[PAGE_LO_POS +: PIN_W]};
  assign ctrl_word        = ctrl_q;
  assign status_cause     = status_q;
  assign page_sel         = ctrl_q[PAGE_LO_POS +: PIN_W];
  assign flash_start_addr = {{ADDR_PAD_W{1'b0}}, page_full, {ADDR_SHIFT{1'b0}}};
  assign wdog_en          = remote_mode & ctrl_q[WDEN_POS];
  assign wdog_limit       = ctrl_q[WDT_POS +: WDT_W];

  AST_STATUS_ONEHOT0: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(status_q)); // R7
  AST_CAUSE_WRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> $onehot(status_q)); // R7
  AST_XRST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && trig_ext_rst) |=> status_q[C_XRST]); // R8
  AST_REMOTE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && remote_mode && !trig_core_req) |=> (ctrl_q == '0)); // R3
  AST_REMOTE_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && remote_mode && (req == (1 << C_CORE))) |=> (ctrl_q == $past(upd_word))); // R4
  AST_LOCAL_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !remote_mode) |=> (ctrl_q == '0 || ctrl_q == local_app_word())); // R5
  AST_BUSY_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    loading |=> ($stable(ctrl_q) && $stable(status_q))); // R10
  AST_UPDATE_KICKS: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> load_start); // R9
endmodule

// File: tb/imgsel_ctrl_bench.sv
module imgsel_ctrl_bench;
  localparam int B_CRC = 0, B_STAT = 1, B_CORE = 2, B_XRST = 3, B_WDOG = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic remote_mode = 1'b1;
  logic t_xrst = 0, t_stat = 0, t_crc = 0, t_core = 0, t_wdog = 0;
  logic [20:0] upd_word = '0;
  logic load_done = 1'b0;
  logic [20:0] ctrl_word;
  logic [4:0]  status_cause;
  logic [2:0]  page_sel;
  logic [23:0] flash_start_addr;
  logic        wdog_en;
  logic [11:0] wdog_limit;
  logic        load_start, loading;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  logic [25:0] expq[$];
  string       tagq[$];

  always #10 clk = ~clk;

  imgsel_ctrl u_imgsel_ctrl (
    .clk(clk), .rst_n(rst_n), .remote_mode(remote_mode),
    .trig_ext_rst(t_xrst), .trig_stat_err(t_stat), .trig_crc_err(t_crc),
    .trig_core_req(t_core), .trig_wdog_to(t_wdog), .upd_word(upd_word),
    .load_done(load_done), .ctrl_word(ctrl_word), .status_cause(status_cause),
    .page_sel(page_sel), .flash_start_addr(flash_start_addr), .wdog_en(wdog_en),
    .wdog_limit(wdog_limit), .load_start(load_start), .loading(loading)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [20:0] mk_word(input bit app, input logic [6:0] page,
                                          input bit wden, input logic [11:0] lim);
    return {lim, wden, page[6:3], page[2:0], app};
  endfunction

  // expected outcome: {ctrl, cause}
  function automatic logic [25:0] model(input bit rmode, input logic [4:0] trg,
                                        input logic [20:0] upd);
    logic [4:0] win;
    logic [20:0] c;
    win = '0;
    if (trg[B_XRST]) win[B_XRST] = 1;
    else if (trg[B_STAT]) win[B_STAT] = 1;
    else if (trg[B_CRC]) win[B_CRC] = 1;
    else if (trg[B_WDOG]) win[B_WDOG] = 1;
    else if (trg[B_CORE]) win[B_CORE] = 1;
    c = '0;
    if (rmode && win[B_CORE]) c = upd;
    if (!rmode && (win[B_XRST] || win[B_CORE])) c = 21'h000003;
    return {c, win};
  endfunction

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && load_start) begin
      if (expq.size() == 0) begin
        chk("R9 unexpected load_start", 1, 0);
      end else begin
        logic [25:0] e;
        string t;
        logic [6:0] pg;
        e = expq.pop_front();
        t = tagq.pop_front();
        pg = {e[12:9], e[8:6]};
        chk({t, " ctrl"}, ctrl_word, e[25:5]);
        chk({"R7 cause ", t}, status_cause, e[4:0]);
        chk({"R2 page_sel ", t}, page_sel, pg[2:0]);
        chk({"R2 addr ", t}, flash_start_addr, {1'b0, pg, 16'h0});
        chk({"R11 limit ", t}, wdog_limit, e[25:14]);
        chk({"R11 wden ", t}, wdog_en, remote_mode & e[13]);
      end
    end
  end

  task automatic finish_load();
    @(negedge clk);
    chk("R9 loading during wait", loading, 1);
    load_done = 1;
    @(negedge clk);
    load_done = 0;
    chk("R9 loading after done", loading, 0);
  endtask

  task automatic do_reset(input bit mode);
    @(negedge clk);
    rst_n = 0;
    remote_mode = mode;
    expq.push_back({mode ? 21'h0 : 21'h000003, 5'h0});
    tagq.push_back("R1 powerup");
    repeat (3) @(negedge clk);
    chk("R1 reset ctrl", ctrl_word, mode ? 21'h0 : 21'h000003);
    chk("R1 reset cause", status_cause, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 start after reset", load_start, 1);
    finish_load();
  endtask

  task automatic fire(input logic [4:0] trg, input logic [20:0] upd, input string tag);
    upd_word = upd;
    t_crc = trg[B_CRC]; t_stat = trg[B_STAT]; t_core = trg[B_CORE];
    t_xrst = trg[B_XRST]; t_wdog = trg[B_WDOG];
    expq.push_back(model(remote_mode, trg, upd));
    tagq.push_back(tag);
    @(negedge clk);
    {t_crc, t_stat, t_core, t_xrst, t_wdog} = '0;
    chk({"R9 pulse ", tag}, load_start, 1);
    finish_load();
  endtask

  initial begin
    logic [20:0] w1;
    logic [20:0] hold_c;
    w1 = mk_word(1, 7'h5A, 1, 12'hABC);

    do_reset(1);
    chk("R11 wden remote reset", wdog_en, 0);
    fire(5'b00100, w1, "R4 remote core copy");
    fire(5'b00001, w1, "R3 remote crc");
    fire(5'b00100, mk_word(1, 7'h03, 0, 12'h001), "R4 remote core copy2");
    fire(5'b10000, w1, "R3 remote wdog");
    fire(5'b00010, w1, "R3 remote stat");
    fire(5'b01000, w1, "R3 remote xrst");
    // priority chain
    fire(5'b11111, w1, "R8 all xrst wins");
    fire(5'b10111, w1, "R8 stat wins");
    fire(5'b10101, w1, "R8 crc wins");
    fire(5'b10100, w1, "R8 wdog over core");

    // R10: triggers during load ignored
    @(negedge clk);
    upd_word = w1; t_core = 1;
    expq.push_back(model(1, 5'b00100, w1)); tagq.push_back("R10 setup");
    @(negedge clk);
    t_core = 0; t_crc = 1;       // state KICK
    @(negedge clk);
    t_crc = 0; t_xrst = 1;       // state WAIT
    @(negedge clk);
    t_xrst = 0;
    chk("R10 ctrl held", ctrl_word, w1);
    chk("R10 cause held", status_cause, 5'b00100);
    load_done = 1;
    @(negedge clk);
    load_done = 0;
    @(negedge clk);
    chk("R10 ctrl after done", ctrl_word, w1);
    chk("R10 no extra start", load_start, 0);

    // R11: mode flip gates watchdog enable
    chk("R11 wden remote", wdog_en, 1);
    remote_mode = 0;
    @(negedge clk);
    chk("R11 wden forced off", wdog_en, 0);
    chk("R11 limit visible", wdog_limit, 12'hABC);
    remote_mode = 1;

    // local mode
    do_reset(0);
    chk("R11 wden local reset", wdog_en, 0);
    fire(5'b00100, 21'h1FFFFF, "R5 local core ignores upd");
    fire(5'b00001, w1, "R6 local crc");
    fire(5'b01000, w1, "R5 local xrst");
    fire(5'b10000, w1, "R6 local wdog");
    fire(5'b00100, w1, "R5 local core again");
    fire(5'b00010, w1, "R6 local stat");
    fire(5'b10100, w1, "R8 local wdog over core");
    hold_c = ctrl_word;
    chk("R6 local ctrl cleared", hold_c, 0);

    repeat (2) @(negedge clk);
    chk("R9 scoreboard drained", expq.size(), 0);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule